// File: doc/BRIEF.md
# Battery Thermistor Range Classifier

This block watches the safety resistor of a smart battery pack. An external converter reports the measured resistance in ohms with a one-cycle valid strobe. The block sorts each reading into one of five ranges (open, cold, ideal, hot, underrange) using four fixed trip resistances, and keeps the latest range as a registered status code.

Measurements are requested by a single-cycle pulse on `meas_req`. The interval between requests is counted in 1 ms ticks: a short interval while the AC adapter is present and a long one while it is absent. Whenever a valid reading lands in a range different from the stored one, the active-low alert output is driven low and held there until the host pulses the clear strobe, which it does when it reads the status.

Top module: `therm_range_mon`

## Requirements
- R1: A reading at or above 100000 ohms yields range code 0 (open).
- R2: A reading from 30000 up to 99999 ohms yields range code 1 (cold).
- R3: A reading from 3000 up to 29999 ohms yields range code 2 (ideal).
- R4: A reading from 500 up to 2999 ohms yields range code 3 (hot); a reading below 500 ohms yields range code 4 (underrange).
- R5: A reading exactly equal to a trip resistance (100000, 30000, 3000, 500) is placed in the higher-resistance range.
- R6: With `ac_present` high, `meas_req` is a one-cycle pulse issued in the cycle after every 32nd tick.
- R7: With `ac_present` low, `meas_req` is a one-cycle pulse issued in the cycle after every 250th tick.
- R8: Any change of `ac_present` restarts the interval count from zero; a tick in the same cycle as the change is not counted.
- R9: After reset `range_code` is 0 and `alert_n` is 1; `range_code` takes the new range in the cycle after `meas_valid` and does not change in cycles without `meas_valid`.
- R10: `alert_n` goes low in the cycle after a valid reading whose range differs from the stored code; a reading in the same range leaves `alert_n` unchanged.
- R11: Once low, `alert_n` stays low until `alert_clr` is pulsed, and returns high in the cycle after the strobe.
- R12: A range change in the same cycle as `alert_clr` keeps `alert_n` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| ac_present | input | 1 | High while the AC adapter is present |
| meas_valid | input | 1 | Strobe marking a valid resistance reading |
| meas_ohms | input | RES_W | Measured resistance in ohms |
| alert_clr | input | 1 | Host status-read strobe that clears the alert |
| meas_req | output | 1 | One-cycle request for a new measurement |
| range_code | output | 3 | Stored range: 0 open, 1 cold, 2 ideal, 3 hot, 4 underrange |
| alert_n | output | 1 | Active-low alert, low after a range change |

## Verification
The classifier is driven with a mid-range reading in every band and with each trip value and the ohm just below it, so that an off-by-one or a swapped comparison shows up as a wrong code at a boundary. The alert is tried with a changing reading, a repeated reading of the same range, an idle stretch, and a change coinciding with the clear strobe, which separates set-over-clear priority from a plain level. The scheduler runs with the adapter present, absent, and toggled mid-interval, so the index of the first request tells the two intervals apart and shows whether the restart happened.

// File: rtl/therm_range_pkg.sv
package therm_range_pkg;

    typedef enum logic [2:0] {
        RANGE_OPEN  = 3'd0,
        RANGE_COLD  = 3'd1,
        RANGE_IDEAL = 3'd2,
        RANGE_HOT   = 3'd3,
        RANGE_UNDER = 3'd4
    } range_e;

    localparam int unsigned NUM_TRIPS = 4;

endpackage

// File: rtl/therm_classify.sv
module therm_classify
    import therm_range_pkg::*;
#(
    parameter int unsigned RES_W      = 20,
    parameter int unsigned TRIP_OPEN  = 100000,
    parameter int unsigned TRIP_COLD  = 30000,
    parameter int unsigned TRIP_HOT   = 3000,
    parameter int unsigned TRIP_UNDER = 500
) (
    input  logic [RES_W-1:0] ohms,
    output range_e           cls
);

    // Trip points, highest resistance first. A reading at or above
    // entry i lies in range i or a colder one.
    localparam logic [RES_W-1:0] TRIP_VEC [NUM_TRIPS] = '{
        RES_W'(TRIP_OPEN), RES_W'(TRIP_COLD), RES_W'(TRIP_HOT), RES_W'(TRIP_UNDER)
    };

    logic [NUM_TRIPS-1:0] at_or_above;

    for (genvar i = 0; i < NUM_TRIPS; i++) begin : g_trip
        assign at_or_above[i] = (ohms >= TRIP_VEC[i]);
    end

    // Monotone trips: the range index is the number of trips not reached.
    always_comb begin
        int unsigned n_hit;
        n_hit = 0;
        for (int i = 0; i < NUM_TRIPS; i++) begin
            n_hit = n_hit + 32'(at_or_above[i]);
        end
        cls = range_e'(3'(NUM_TRIPS - n_hit));
    end

endmodule

// File: rtl/therm_sched.sv
module therm_sched #(
    parameter int unsigned PERIOD_AC   = 32,
    parameter int unsigned PERIOD_BATT = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ac_present,
    output logic req
);

    localparam int unsigned PMAX  = (PERIOD_AC > PERIOD_BATT) ? PERIOD_AC : PERIOD_BATT;
    localparam int unsigned CNT_W = (PMAX > 2) ? $clog2(PMAX) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ac;
        logic             req;
    } sched_t;

    sched_t sched_d, sched_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        sched_d     = sched_q;
        sched_d.req = 1'b0;
        sched_d.ac  = ac_present;
        limit       = ac_present ? CNT_W'(PERIOD_AC - 1) : CNT_W'(PERIOD_BATT - 1);
        if (ac_present != sched_q.ac) begin
            sched_d.cnt = '0;
        end else if (tick) begin
            if (sched_q.cnt >= limit) begin
                sched_d.cnt = '0;
                sched_d.req = 1'b1;
            end else begin
                sched_d.cnt = sched_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sched_q <= '0;
        end else begin
            sched_q <= sched_d;
        end
    end

    assign req = sched_q.req;

endmodule

// File: rtl/therm_status.sv
module therm_status
    import therm_range_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   meas_valid,
    input  range_e cls,
    input  logic   alert_clr,
    output range_e code,
    output logic   alert_n
);

    typedef struct packed {
        range_e code;
        logic   alert;
    } stat_t;

    stat_t stat_d, stat_q;
    logic  changed;

    always_comb begin
        stat_d  = stat_q;
        changed = meas_valid && (cls != stat_q.code);
        if (meas_valid) begin
            stat_d.code = cls;
        end
        // A new change wins over a clear in the same cycle.
        stat_d.alert = changed | (stat_q.alert & ~alert_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '{code: RANGE_OPEN, alert: 1'b0};
        end else begin
            stat_q <= stat_d;
        end
    end

    assign code    = stat_q.code;
    assign alert_n = ~stat_q.alert;

endmodule

// File: rtl/therm_range_mon.sv
module therm_range_mon
    import therm_range_pkg::*;
#(
    parameter int unsigned RES_W       = 20,
    parameter int unsigned TRIP_OPEN   = 100000,
    parameter int unsigned TRIP_COLD   = 30000,
    parameter int unsigned TRIP_HOT    = 3000,
    parameter int unsigned TRIP_UNDER  = 500,
    parameter int unsigned PERIOD_AC   = 32,
    parameter int unsigned PERIOD_BATT = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1ms,
    input  logic             ac_present,
    input  logic             meas_valid,
    input  logic [RES_W-1:0] meas_ohms,
    input  logic             alert_clr,
    output logic             meas_req,
    output logic [2:0]       range_code,
    output logic             alert_n
);

    range_e cls;
    range_e code;

    therm_classify #(
        .RES_W      (RES_W),
        .TRIP_OPEN  (TRIP_OPEN),
        .TRIP_COLD  (TRIP_COLD),
        .TRIP_HOT   (TRIP_HOT),
        .TRIP_UNDER (TRIP_UNDER)
    ) u_classify (
        .ohms (meas_ohms),
        .cls  (cls)
    );

    therm_sched #(
        .PERIOD_AC   (PERIOD_AC),
        .PERIOD_BATT (PERIOD_BATT)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_1ms),
        .ac_present (ac_present),
        .req        (meas_req)
    );

    therm_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_valid (meas_valid),
        .cls        (cls),
        .alert_clr  (alert_clr),
        .code       (code),
        .alert_n    (alert_n)
    );

    assign range_code = code;

endmodule

// File: rtl/therm_range_mon_chk.sv
module therm_range_mon_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       meas_valid,
    input logic       alert_clr,
    input logic       meas_req,
    input logic [2:0] range_code,
    input logic       alert_n
);

    // R9: code only moves after a valid reading
    p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid |=> $stable(range_code));

    // R9: code stays within the five defined ranges
    p_code_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        range_code <= 3'd4);

    // R10: a code change is always accompanied by the alert
    p_change_alerts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(range_code) |-> !alert_n);

    // R11: alert is held while no clear arrives
    p_alert_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!alert_n && !alert_clr) |=> !alert_n);

    // R11: a clear without a reading releases the alert
    p_clear_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_clr && !meas_valid) |=> alert_n);

    // R6: request is a single-cycle pulse
    p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        meas_req |=> !meas_req);

endmodule

bind therm_range_mon therm_range_mon_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_valid (meas_valid),
    .alert_clr  (alert_clr),
    .meas_req   (meas_req),
    .range_code (range_code),
    .alert_n    (alert_n)
);

// File: tb/therm_range_mon_bench.sv
module therm_range_mon_bench;

    localparam int RES_W = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_1ms = 1'b0;
    logic             ac_present = 1'b1;
    logic             meas_valid = 1'b0;
    logic [RES_W-1:0] meas_ohms = '0;
    logic             alert_clr = 1'b0;
    logic             meas_req;
    logic [2:0]       range_code;
    logic             alert_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    therm_range_mon u_therm_range_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_1ms   (tick_1ms),
        .ac_present (ac_present),
        .meas_valid (meas_valid),
        .meas_ohms  (meas_ohms),
        .alert_clr  (alert_clr),
        .meas_req   (meas_req),
        .range_code (range_code),
        .alert_n    (alert_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply one reading; outputs sampled at the following negedge.
    task automatic measure(input int ohms);
        @(negedge clk);
        meas_valid = 1'b1;
        meas_ohms  = RES_W'(ohms);
        @(negedge clk);
        meas_valid = 1'b0;
    endtask

    task automatic clear_alert();
        @(negedge clk);
        alert_clr = 1'b1;
        @(negedge clk);
        alert_clr = 1'b0;
    endtask

    // Issue n ticks, one idle cycle between them; report the index of the
    // first tick followed by a request and the number of requests seen.
    task automatic run_ticks(input int n, output int first, output int count);
        first = 0;
        count = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            tick_1ms = 1'b1;
            @(negedge clk);
            tick_1ms = 1'b0;
            if (meas_req) begin
                count++;
                if (first == 0) first = i;
            end
        end
    endtask

    task automatic t_reset();
        check("R9 reset code", int'(range_code), 0);
        check("R9 reset alert", int'(alert_n), 1);
        check("R6 reset req", int'(meas_req), 0);
    endtask

    task automatic t_bands();
        measure(50000);
        check("R2 cold", int'(range_code), 1);
        check("R10 alert on change", int'(alert_n), 0);
        clear_alert();
        check("R11 clear", int'(alert_n), 1);
        measure(10000);  check("R3 ideal", int'(range_code), 2);
        measure(1500);   check("R4 hot", int'(range_code), 3);
        measure(100);    check("R4 under", int'(range_code), 4);
        measure(250000); check("R1 open", int'(range_code), 0);
        measure(100000); check("R5 at open trip", int'(range_code), 0);
        measure(99999);  check("R5 below open trip", int'(range_code), 1);
        measure(30000);  check("R5 at cold trip", int'(range_code), 1);
        measure(29999);  check("R5 below cold trip", int'(range_code), 2);
        measure(3000);   check("R5 at hot trip", int'(range_code), 2);
        measure(2999);   check("R5 below hot trip", int'(range_code), 3);
        measure(500);    check("R5 at under trip", int'(range_code), 3);
        measure(499);    check("R5 below under trip", int'(range_code), 4);
    endtask

    task automatic t_alert();
        clear_alert();
        check("R11 clear before", int'(alert_n), 1);
        measure(300);
        check("R10 same range no alert", int'(alert_n), 1);
        check("R10 same range code", int'(range_code), 4);
        measure(20000);
        check("R10 alert set", int'(alert_n), 0);
        repeat (3) @(negedge clk);
        check("R11 alert held", int'(alert_n), 0);
        clear_alert();
        check("R11 alert released", int'(alert_n), 1);
        @(negedge clk);
        meas_valid = 1'b1;
        meas_ohms  = RES_W'(60000);
        alert_clr  = 1'b1;
        @(negedge clk);
        meas_valid = 1'b0;
        alert_clr  = 1'b0;
        check("R12 change with clear", int'(alert_n), 0);
        check("R12 code", int'(range_code), 1);
        clear_alert();
        check("R11 final clear", int'(alert_n), 1);
    endtask

    task automatic t_hold();
        @(negedge clk);
        meas_ohms = RES_W'(200);
        repeat (2) @(negedge clk);
        check("R9 hold without valid", int'(range_code), 1);
        check("R9 alert untouched", int'(alert_n), 1);
    endtask

    task automatic t_ac_present();
        int first, count;
        @(negedge clk);
        ac_present = 1'b0;
        @(negedge clk);
        ac_present = 1'b1;
        @(negedge clk);
        run_ticks(70, first, count);
        check("R6 first request", first, 32);
        check("R6 request count", count, 2);
    endtask

    task automatic t_ac_absent();
        int first, count;
        @(negedge clk);
        ac_present = 1'b0;
        @(negedge clk);
        run_ticks(260, first, count);
        check("R7 first request", first, 250);
        check("R7 request count", count, 1);
    endtask

    task automatic t_restart();
        int first, count;
        @(negedge clk);
        ac_present = 1'b1;
        @(negedge clk);
        run_ticks(20, first, count);
        check("R8 no early request", count, 0);
        @(negedge clk);
        ac_present = 1'b0;
        tick_1ms   = 1'b1;
        @(negedge clk);
        ac_present = 1'b1;
        tick_1ms   = 1'b0;
        @(negedge clk);
        run_ticks(40, first, count);
        check("R8 restarted count", first, 32);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bands();
        t_alert();
        t_hold();
        t_ac_present();
        t_ac_absent();
        t_restart();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule